// File: doc/BRIEF.md
# Host Command Mailbox

This block is a one-deep mailbox between a host computer and an embedded interface processor. On the rising edge of its I/O strobe the host deposits a command of two interface-code bits and one direction bit. The mailbox then marks itself busy. The processor sees a pending flag, and the host sees a not-ready flag. The processor reads the command onto its data bus with a read strobe and frees the mailbox with a clear strobe once the transfer is done.

A single data holding register carries one word in either direction. When the host sends data, its word is captured together with the command and later gated onto the processor bus. When the host receives data, the processor loads the word from its bus ahead of time, and the host's next accepted strobe copies it to the host data lines.

Every strobe is sampled on one clock. Clear, load and host strobes act on their rising edge only. The read strobes are level-sensitive and have no side effects.

Top module: `hcmd_mailbox`

## Requirements
- R1: After synchronous reset, `host_busy` and `proc_pending` are 0, `host_rdata` is 0, and a command read returns 0.
- R2: A rising `host_strobe` while ready captures `host_code` and `host_dir`, and sets the busy state from the next cycle.
- R3: `host_busy` (high means not ready) and `proc_pending` are both 1 exactly while the mailbox is busy.
- R4: A `host_strobe` rising edge while busy is ignored. The command, the data word and `host_rdata` are all left unchanged.
- R5: While `proc_rd_cmd` is high, `proc_bus_oe` is 1 and `proc_bus_out` holds the code in bits 1:0 and the direction in bit 2, with the upper bits 0.
- R6: A rising `proc_clr_cmd` empties the mailbox: from the next cycle it is ready and the command reads 0. If an accepted host strobe arrives in the same cycle, the host strobe wins.
- R7: With `host_dir`=1 (host to processor), an accepted strobe captures `host_wdata`. While `proc_rd_data` is high and `proc_rd_cmd` is low, that word is driven on the bus.
- R8: A rising `proc_ld_data` latches `proc_bus_in`. The next accepted strobe with `host_dir`=0 (processor to host) copies the word to `host_rdata`.
- R9: `proc_bus_oe` is 0 when neither read strobe is high. If both are high, the command is driven.
- R10: A strobe held high acts once. A host strobe still high after a clear does not re-arm the mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_strobe | input | 1 | Host I/O strobe |
| host_code | input | 2 | Interface code bits |
| host_dir | input | 1 | 1: host to processor, 0: processor to host |
| host_wdata | input | W | Word from host |
| host_rdata | output | W | Word delivered to host |
| host_busy | output | 1 | High = not ready |
| proc_pending | output | 1 | Command pending for processor |
| proc_rd_cmd | input | 1 | Read command strobe |
| proc_clr_cmd | input | 1 | Clear command strobe |
| proc_rd_data | input | 1 | Read data word strobe |
| proc_ld_data | input | 1 | Load data word strobe |
| proc_bus_in | input | W | Processor bus into mailbox |
| proc_bus_out | output | W | Value driven onto processor bus |
| proc_bus_oe | output | 1 | Bus drive enable |

## Verification
The capture path is exercised with distinct code and direction patterns and with distinct data words in each direction. These patterns reveal swapped code bits, a misplaced direction bit, and a data word routed the wrong way. Strobes sent while busy use different codes and data, so any leak would be visible. A strobe that coincides with a clear, and a strobe held high across a clear, separate the priority and edge-detection rules from a simple level latch.

// File: rtl/hcmd_mailbox.sv
module hcmd_mailbox #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         host_strobe,
  input  logic [1:0]   host_code,
  input  logic         host_dir,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  output logic         host_busy,
  output logic         proc_pending,
  input  logic         proc_rd_cmd,
  input  logic         proc_clr_cmd,
  input  logic         proc_rd_data,
  input  logic         proc_ld_data,
  input  logic [W-1:0] proc_bus_in,
  output logic [W-1:0] proc_bus_out,
  output logic         proc_bus_oe
);
  localparam int PADW = W - 3;

  logic         hs_q, clr_q, ld_q;
  logic         busy;
  logic [1:0]   code;
  logic         dir;
  logic [W-1:0] word;
  logic [W-1:0] cmd_word;
  logic         hs_edge, clr_edge, ld_edge, accept;

  assign hs_edge  = host_strobe & ~hs_q;
  assign clr_edge = proc_clr_cmd & ~clr_q;
  assign ld_edge  = proc_ld_data & ~ld_q;
  assign accept   = hs_edge & ~busy;

  always_ff @(posedge clk) begin
    hs_q  <= host_strobe;
    clr_q <= proc_clr_cmd;
    ld_q  <= proc_ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      code       <= '0;
      dir        <= 1'b0;
      word       <= '0;
      host_rdata <= '0;
    end else begin
      if (ld_edge) word <= proc_bus_in;
      if (accept) begin
        busy <= 1'b1;
        code <= host_code;
        dir  <= host_dir;
        if (host_dir) word <= host_wdata;
        else          host_rdata <= word;
      end else if (clr_edge) begin
        busy <= 1'b0;
        code <= '0;
        dir  <= 1'b0;
      end
    end
  end

  assign cmd_word     = {{PADW{1'b0}}, dir, code};
  assign host_busy    = busy;
  assign proc_pending = busy;
  assign proc_bus_oe  = proc_rd_cmd | proc_rd_data;
  assign proc_bus_out = proc_rd_cmd  ? cmd_word :
                        proc_rd_data ? word     : '0;
endmodule

module hcmd_mailbox_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         host_strobe,
  input logic         host_dir,
  input logic         host_busy,
  input logic         proc_pending,
  input logic         proc_rd_cmd,
  input logic         proc_rd_data,
  input logic         proc_clr_cmd,
  input logic         proc_ld_data,
  input logic [W-1:0] proc_bus_in,
  input logic [W-1:0] proc_bus_out,
  input logic         proc_bus_oe
);
  // R2
  take_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(host_strobe) && !host_busy) |=> host_busy);

  // R4
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (host_busy && !$rose(proc_clr_cmd)) |=> host_busy);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(proc_clr_cmd) && !($rose(host_strobe) && !host_busy)) |=> !host_busy);

  // R3
  flags_agree_chk: assert property (@(posedge clk) disable iff (rst)
    host_busy == proc_pending);

  // R9
  bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!proc_rd_cmd && !proc_rd_data) |-> !proc_bus_oe);

  // R8
  load_word_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(proc_ld_data) && !($rose(host_strobe) && !host_busy && host_dir))
    |=> (!(proc_rd_data && !proc_rd_cmd) || proc_bus_out == $past(proc_bus_in)));
endmodule

bind hcmd_mailbox hcmd_mailbox_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .host_strobe(host_strobe), .host_dir(host_dir),
  .host_busy(host_busy), .proc_pending(proc_pending),
  .proc_rd_cmd(proc_rd_cmd), .proc_rd_data(proc_rd_data),
  .proc_clr_cmd(proc_clr_cmd), .proc_ld_data(proc_ld_data),
  .proc_bus_in(proc_bus_in), .proc_bus_out(proc_bus_out),
  .proc_bus_oe(proc_bus_oe)
);

// File: tb/hcmd_mailbox_bench.sv
module hcmd_mailbox_bench;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic host_strobe = 0, host_dir = 0;
  logic [1:0] host_code = 0;
  logic [W-1:0] host_wdata = 0, proc_bus_in = 0;
  logic proc_rd_cmd = 0, proc_clr_cmd = 0, proc_rd_data = 0, proc_ld_data = 0;
  logic [W-1:0] host_rdata, proc_bus_out;
  logic host_busy, proc_pending, proc_bus_oe;
  int total = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hcmd_mailbox #(.W(W)) u_hcmd_mailbox (.*);

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_cmd(string req, logic [W-1:0] exp);
    @(negedge clk) proc_rd_cmd = 1;
    #1 check(req, proc_bus_out, exp);
    check(req, W'(proc_bus_oe), 1);
    proc_rd_cmd = 0;
  endtask

  task automatic read_data(string req, logic [W-1:0] exp);
    @(negedge clk) proc_rd_data = 1;
    #1 check(req, proc_bus_out, exp);
    proc_rd_data = 0;
  endtask

  task automatic hstrobe(logic [1:0] c, logic d, logic [W-1:0] wd);
    @(negedge clk) begin host_code = c; host_dir = d; host_wdata = wd; host_strobe = 1; end
    @(negedge clk) host_strobe = 0;
  endtask

  task automatic pclear();
    @(negedge clk) proc_clr_cmd = 1;
    @(negedge clk) proc_clr_cmd = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy", W'(host_busy), 0);
    check("R1 pending", W'(proc_pending), 0);
    check("R1 rdata", host_rdata, 0);
    check("R1 oe", W'(proc_bus_oe), 0);
    read_cmd("R1 cmd", 0);
  endtask

  task automatic t_capture();
    hstrobe(2'b10, 1'b1, 8'hA5);
    check("R2 busy", W'(host_busy), 1);
    check("R3 pending", W'(proc_pending), 1);
    read_cmd("R5 cmd word", 8'h06);
    read_data("R7 data word", 8'hA5);
    @(negedge clk) begin proc_rd_cmd = 1; proc_rd_data = 1; end
    #1 check("R9 priority", proc_bus_out, 8'h06);
    proc_rd_cmd = 0; proc_rd_data = 0;
    #1 check("R9 idle oe", W'(proc_bus_oe), 0);
  endtask

  task automatic t_ignore();
    hstrobe(2'b01, 1'b0, 8'h3C);
    read_cmd("R4 cmd kept", 8'h06);
    read_data("R4 data kept", 8'hA5);
    check("R4 rdata kept", host_rdata, 0);
    check("R4 still busy", W'(host_busy), 1);
  endtask

  task automatic t_clear();
    pclear();
    check("R6 ready", W'(host_busy), 0);
    check("R3 pending low", W'(proc_pending), 0);
    read_cmd("R6 cmd zero", 0);
  endtask

  task automatic t_outbound();
    @(negedge clk) begin proc_bus_in = 8'h5A; proc_ld_data = 1; end
    @(negedge clk) proc_ld_data = 0;
    read_data("R8 loaded", 8'h5A);
    hstrobe(2'b01, 1'b0, 8'hFF);
    check("R8 delivered", host_rdata, 8'h5A);
    read_cmd("R2 dir0 cmd", 8'h01);
    read_data("R8 data kept", 8'h5A);
    pclear();
  endtask

  task automatic t_held();
    @(negedge clk) begin host_code = 2'b11; host_dir = 1; host_wdata = 8'h77; host_strobe = 1; end
    @(negedge clk) check("R10 first", W'(host_busy), 1);
    pclear();
    repeat (3) @(negedge clk);
    check("R10 no rearm", W'(host_busy), 0);
    host_strobe = 0;
  endtask

  task automatic t_collide();
    @(negedge clk) begin host_code = 2'b10; host_dir = 0; host_strobe = 1; proc_clr_cmd = 1; end
    @(negedge clk) begin host_strobe = 0; proc_clr_cmd = 0; end
    check("R6 strobe wins", W'(host_busy), 1);
    read_cmd("R6 collide cmd", 8'h02);
    pclear();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_capture();
    t_ignore();
    t_clear();
    t_outbound();
    t_held();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule